// File: doc/BRIEF.md
# Pipelined Byte-Write Synchronous Memory

This block is a single-port synchronous memory 36 bits wide. The word is split into four 9-bit lanes, each holding 8 data bits and 1 parity bit. The word address comes already registered from an external burst sequencer. Address, control and write data are all captured on the rising clock edge. A write finishes inside the block with no extra timing from outside. Read data leaves through an output register, so a read has two pipeline stages.

Three chip enables, two active-low and one active-high, decode whether a cycle reaches the memory. A global write enable writes the whole word. A byte-write enable together with per-lane enables writes single lanes. Any selected cycle that writes no lane is a read. Deselecting the block, or raising the power-down input, stops the output at the next edge. Power-down also blocks every access and keeps the stored contents. An active-low output enable gates the output combinationally.

Top module: `pbw_sync_mem`

## Requirements
- R1: A read accepted at rising edge E presents the stored word on `rdata` with `rvalid` high after edge E+1, provided the block is still selected at edge E+1.
- R2: With `gwr_n` low in a selected cycle, all 36 bits are written, whatever `bwr_n` and `lane_wr_n` are.
- R3: With `gwr_n` high and `bwr_n` low, each lane i whose `lane_wr_n[i]` is 0 is written. Lane i is bits 9*i+8..9*i. The other lanes keep their old value, and a later read returns the merged word.
- R4: A selected cycle with `gwr_n` high and either `bwr_n` high or `lane_wr_n` all ones is a read and changes no stored data.
- R5: A cycle is selected only when `ce_a_n`=0, `ce_hi`=1, `ce_b_n`=0 and `sleep`=0. Writes in any other cycle are ignored.
- R6: `rvalid` is high only for a selected read captured two edges earlier and followed by a selected cycle. A write never raises it.
- R7: A deselected cycle following a read drops `rvalid` at the very next edge, which cancels that read's output.
- R8: While `oe_n` is 1, `rvalid` and `rdata` are 0 at once, without waiting for a clock edge. Stored data and the pipeline are not affected.
- R9: While `sleep` is 1 no access is accepted, `rvalid` is low after the next edge, and stored contents are kept.
- R10: During and right after reset, `rvalid` is 0 and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_hi | input | 1 | Chip enable, active high |
| ce_b_n | input | 1 | Chip enable, active low |
| sleep | input | 1 | Power-down; blocks accesses, keeps contents |
| gwr_n | input | 1 | Whole-word write, active low |
| bwr_n | input | 1 | Lane-write function enable, active low |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| oe_n | input | 1 | Combinational output enable, active low |
| rdata | output | 36 | Read data, 0 when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
Each read result is due after the second rising edge following the cycle that issues the read. Whether it is valid also depends on the select state and `oe_n` of the cycle in between. The driver therefore queues the expected result one cycle later, once that next cycle's inputs are known. The monitor pops and compares it 3 ns after the following rising edge. Writes are checked through later reads, using a reference memory that the driver updates in the cycle the write is issued. Ignored writes and power-down cycles are checked the same way.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/pbw_decode.sv
module pbw_decode #(
  parameter int LANES = 4
) (
  input  logic             ce_a_n,
  input  logic             ce_hi,
  input  logic             ce_b_n,
  input  logic             sleep,
  input  logic             gwr_n,
  input  logic             bwr_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic             acc_sel,
  output pbw_pkg::op_e     op,
  output logic [LANES-1:0] wmask
);
  logic [LANES-1:0] raw_mask;

  always_comb begin
    acc_sel = !ce_a_n && ce_hi && !ce_b_n && !sleep;
    if (!gwr_n)      raw_mask = '1;          // whole word wins
    else if (!bwr_n) raw_mask = ~lane_wr_n;  // selected lanes only
    else             raw_mask = '0;
    wmask = acc_sel ? raw_mask : '0;
    if (!acc_sel)      op = pbw_pkg::OP_IDLE;
    else if (|raw_mask) op = pbw_pkg::OP_WRITE;
    else               op = pbw_pkg::OP_READ;
  end
endmodule

// File: rtl/pbw_lane_ram.sv
module pbw_lane_ram #(
  parameter int ADDR_W = 6,
  parameter int W      = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wd,
  output logic [W-1:0]      rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) rd <= mem[addr];
  end
endmodule

// File: rtl/pbw_sync_mem.sv
module pbw_sync_mem #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_a_n,
  input  logic              ce_hi,
  input  logic              ce_b_n,
  input  logic              sleep,
  input  logic              gwr_n,
  input  logic              bwr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic              acc_sel;
  pbw_pkg::op_e      op;
  logic [LANES-1:0]  wmask;

  pbw_pkg::op_e      s1_op;
  logic [LANES-1:0]  s1_mask;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] s1_wdata;
  logic [DATA_W-1:0] rd_word;
  logic              valid_q;
  logic              s1_rd;

  pbw_decode #(.LANES(LANES)) u_dec (
    .ce_a_n(ce_a_n), .ce_hi(ce_hi), .ce_b_n(ce_b_n), .sleep(sleep),
    .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_wr_n(lane_wr_n),
    .acc_sel(acc_sel), .op(op), .wmask(wmask)
  );

  // Stage 1: capture the access.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op   <= pbw_pkg::OP_IDLE;
      s1_mask <= '0;
    end else begin
      s1_op   <= op;
      s1_mask <= wmask;
    end
  end

  always_ff @(posedge clk) begin
    s1_addr  <= addr;
    s1_wdata <= wdata;
  end

  assign s1_rd = (s1_op == pbw_pkg::OP_READ);

  // Stage 2: array access into the output register, one RAM per lane.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pbw_lane_ram #(.ADDR_W(ADDR_W), .W(LANE_W)) u_ram (
      .clk(clk),
      .we(s1_mask[g]),
      .re(s1_rd),
      .addr(s1_addr),
      .wd(s1_wdata[g*LANE_W +: LANE_W]),
      .rd(rd_word[g*LANE_W +: LANE_W])
    );
  end

  // A deselect or power-down in the current cycle kills the output at this edge.
  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= s1_rd && acc_sel;
  end

  assign rvalid = valid_q && !oe_n;
  assign rdata  = rvalid ? rd_word : '0;
endmodule

// File: rtl/pbw_sync_mem_chk.sv
module pbw_sync_mem_chk #(
  parameter int LANES  = 4,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_a_n,
  input logic              ce_hi,
  input logic              ce_b_n,
  input logic              sleep,
  input logic              gwr_n,
  input logic              bwr_n,
  input logic [LANES-1:0]  lane_wr_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] rdata,
  input logic              rvalid
);
  logic sel_now;
  logic rd_req;
  assign sel_now = !ce_a_n && ce_hi && !ce_b_n && !sleep;
  assign rd_req  = sel_now && gwr_n && (bwr_n || (&lane_wr_n));

  always_comb begin
    if (oe_n) assert_oe_blank_R8: assert (!rvalid && rdata == '0);
  end

  assert_reset_quiet_R10: assert property (@(posedge clk) rst |=> !rvalid);

  assert_deselect_fast_R7: assert property (@(posedge clk) disable iff (rst)
    (ce_a_n || !ce_hi || ce_b_n) |=> !rvalid);

  assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !rvalid);

  assert_valid_origin_R6: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> ($past(rd_req, 2) && $past(sel_now)));
endmodule

bind pbw_sync_mem pbw_sync_mem_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ce_a_n(ce_a_n), .ce_hi(ce_hi), .ce_b_n(ce_b_n),
  .sleep(sleep), .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_wr_n(lane_wr_n),
  .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid)
);

// File: tb/pbw_sync_mem_bench.sv
module pbw_sync_mem_bench;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_a_n = 1'b1, ce_hi = 1'b0, ce_b_n = 1'b1, sleep = 1'b0;
  logic gwr_n = 1'b1, bwr_n = 1'b1, oe_n = 1'b0;
  logic [LN-1:0] lane_wr_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rvalid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [DW:0] exp_q[$];
  string       tag_q[$];

  logic [DW-1:0] ref_mem [1<<AW];
  bit            prev_rd = 0;
  bit            have_prev = 0;
  logic [DW-1:0] prev_data = '0;
  string         prev_tag = "";

  always #5 clk = ~clk;

  pbw_sync_mem #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_pbw_sync_mem (
    .clk(clk), .rst(rst), .ce_a_n(ce_a_n), .ce_hi(ce_hi), .ce_b_n(ce_b_n),
    .sleep(sleep), .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid)
  );

  task automatic check(input string tag, input logic [DW:0] act, input logic [DW:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got v=%0b d=%h, want v=%0b d=%h",
               tag, act[DW], act[DW-1:0], exp[DW], exp[DW-1:0]);
    end
  endtask

  // One bus cycle, driven at the falling edge.
  task automatic cyc(input bit a_n, input bit hi, input bit b_n, input bit slp,
                     input bit g_n, input bit bw_n, input logic [LN-1:0] lw_n,
                     input int ad, input logic [DW-1:0] wd, input bit oen,
                     input string tag);
    bit sel;
    logic [LN-1:0] mask;
    @(negedge clk);
    sel = !a_n && hi && !b_n && !slp;
    if (have_prev) begin
      bit v;
      v = prev_rd && sel && !oen;
      exp_q.push_back({v, v ? prev_data : {DW{1'b0}}});
      tag_q.push_back(prev_tag);
    end
    mask = !g_n ? '1 : (!bw_n ? ~lw_n : '0);
    if (sel && |mask)
      for (int l = 0; l < LN; l++)
        if (mask[l]) ref_mem[ad][l*LW +: LW] = wd[l*LW +: LW];
    prev_rd   = sel && !(|mask);
    prev_data = ref_mem[ad];
    prev_tag  = tag;
    have_prev = 1;
    ce_a_n = a_n; ce_hi = hi; ce_b_n = b_n; sleep = slp;
    gwr_n = g_n; bwr_n = bw_n; lane_wr_n = lw_n;
    addr = AW'(ad); wdata = wd; oe_n = oen;
  endtask

  task automatic wr_all(input int ad, input logic [DW-1:0] wd, input string tag);
    cyc(0, 1, 0, 0, 0, 1, 4'hF, ad, wd, 0, tag);
  endtask

  task automatic rd(input int ad, input string tag);
    cyc(0, 1, 0, 0, 1, 1, 4'hF, ad, '0, 0, tag);
  endtask

  // Monitor: one expected item per cycle, 3 ns after the rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (exp_q.size() > 0) begin
        logic [DW:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {rvalid, rdata}, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R10 reset", {rvalid, rdata}, '0);
    @(negedge clk);
    rst = 1'b0;
    // Clear the whole array so every later read has a known reference.
    for (int i = 0; i < (1<<AW); i++) wr_all(i, '0, "R2 clear");
    wr_all(5, 36'h9_8765_4321, "R2 write");
    rd(5, "R1 read a5");
    rd(5, "R1 read a5 again");
    cyc(0, 1, 0, 0, 0, 0, 4'b0110, 6, 36'hA_BCDE_F012, 0, "R2 gw over lanes");
    rd(6, "R2 read a6");
    cyc(0, 1, 0, 0, 1, 0, 4'b1010, 5, 36'h1_1111_1111, 0, "R3 lane write");
    rd(5, "R3 merged read");
    cyc(0, 1, 0, 0, 1, 0, 4'b1111, 5, 36'hF_FFFF_FFFF, 0, "R4 no-lane cycle is read");
    cyc(0, 1, 0, 0, 1, 1, 4'b0000, 5, 36'hE_EEEE_EEEE, 0, "R4 bwr_n high is read");
    rd(5, "R4 data unchanged");
    wr_all(7, 36'h3_3C3C_5A5A, "R5 setup");
    cyc(1, 1, 0, 0, 0, 1, 4'hF, 7, 36'h0_DEAD_BEEF, 0, "R5 ce_a_n off");
    cyc(0, 0, 0, 0, 0, 1, 4'hF, 7, 36'h0_DEAD_BEEF, 0, "R5 ce_hi off");
    cyc(0, 1, 1, 0, 0, 0, 4'h0, 7, 36'h0_DEAD_BEEF, 0, "R5 ce_b_n off");
    rd(7, "R7 read then deselect");
    cyc(0, 0, 0, 0, 1, 1, 4'hF, 7, '0, 0, "R5 read a7 unchanged");
    rd(7, "R8 read then oe off");
    cyc(0, 1, 0, 0, 1, 1, 4'hF, 7, '0, 1, "R8 oe off read");
    rd(7, "R9 read then sleep");
    cyc(0, 1, 0, 1, 0, 1, 4'hF, 7, 36'h7_7777_7777, 0, "R9 write while asleep");
    cyc(0, 1, 0, 1, 1, 1, 4'hF, 7, '0, 0, "R9 read while asleep");
    rd(7, "R9 contents kept");
    rd(7, "R6 plain read");
    cyc(0, 1, 0, 0, 0, 1, 4'hF, 8, 36'h5_5555_AAAA, 0, "R6 write gives no valid");
    for (int i = 0; i < 12; i++)
      wr_all(16 + i, DW'(36'h1_0203_0405 * (i + 3)), "R2 sweep write");
    for (int i = 0; i < 12; i++)
      cyc(0, 1, 0, 0, 1, 0, LN'(i), 16 + i, DW'(36'hF_0F0F_0F0F ^ i), 0, "R3 sweep lanes");
    for (int i = 0; i < 12; i++) rd(16 + i, "R3 sweep read");
    rd(5, "R1 tail");
    cyc(1, 0, 1, 0, 1, 1, 4'hF, 0, '0, 0, "R7 idle");
    cyc(1, 0, 1, 0, 1, 1, 4'hF, 0, '0, 0, "R7 idle");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    int cnt = 0;
    while (!done && cnt < 5000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout, want completion");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule